// File: doc/BRIEF.md
# Retention Regulator Control Register File

This block is a small memory-mapped register bank that configures one core's low-dropout regulator. A simple synchronous bus with an address, a write enable, write data and combinational read data reaches four words. The first is an update control word. The second holds the regulator reset bit and the retention reference code. The last two are free-form configuration words that go to the regulator unchanged.

The retention reference code is not applied as soon as it is written. Software first writes the new code, which is held pending. It then writes 0 and then 1 to the update word. The 0-to-1 transition takes a snapshot of the pending code and sends a toggle request into the regulator's reference-clock domain. The snapshot becomes the active code once the request has passed a two-flop synchronizer. Software then writes the update word back to 0, and the active code does not move.

A status bit tells software when the active code equals the pending code and no transfer is still in flight. Code 0x20 stands for 0.5 V, and the other codes scale from that point. The block itself carries the code as a plain 7-bit number.

Top module: `ldo_ctl_regfile`

## Requirements
- R1: After reset these values hold: the reference word reads 0x0001_0000, `ldo_rst_o` is 1, both configuration words and `ret_code_o` are 0, and the update word reads 0x2 (update bit 0, status bit 1).
- R2: Offset 0x4 stores all 32 written bits and reads them back. Bit 16 drives `ldo_rst_o`, where 1 holds the regulator in reset. Bits 14:8 form the pending retention code.
- R3: Offsets 0xC and 0x10 each store a full 32-bit word, read it back, and drive `ldo_cfg1_o` and `ldo_cfg2_o` respectively.
- R4: A read of any address other than 0x0, 0x4, 0xC or 0x10 returns 0. A write to such an address changes no stored word and no output.
- R5: Writing the pending code field alone leaves `ret_code_o` unchanged. `ret_code_o` only ever takes the snapshot captured when an update was armed.
- R6: At offset 0x0, bit 0 is stored and read back. A write of 1 while that bit is 0 arms an update, and `ret_code_o` takes the pending code within six reference-clock cycles.
- R7: A write of 1 while the update bit is already 1 starts no transfer. A write of 0 to the update bit leaves `ret_code_o` unchanged.
- R8: Bit 1 of offset 0x0 is a read-only status. It is 1 when the active code equals the pending code and no transfer is in flight. It reads 0 right after the pending code is written to a value different from the active one.
- R9: Every one of the 128 codes, including 0x20 (0.5 V), reaches `ret_code_o` unchanged through the update sequence.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Register bus clock |
| ref_clk | input | 1 | Regulator reference clock that times the update |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| bus_addr | input | 6 | Byte address within the register window |
| bus_we | input | 1 | Write enable, sampled on the rising edge of `clk` |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| ldo_cfg1_o | output | 32 | First regulator configuration word |
| ldo_cfg2_o | output | 32 | Second regulator configuration word |
| ldo_rst_o | output | 1 | Regulator reset level (1 = held in reset) |
| ret_code_o | output | 7 | Active retention reference code, in the `ref_clk` domain |
| code_match_o | output | 1 | Active code equals pending code and no transfer is in flight |

## Verification
The check that the active code only takes the armed snapshot relies on one input rule. Software must not arm a second update while the previous request is still crossing the synchronizer, because otherwise the snapshot could change at the same reference edge that loads it. The bench follows this rule: after every write of 1 to the update word it waits six reference-clock edges and several bus cycles before the next arm. The two clocks are unrelated in period (10 ns and 26 ns), so the request arrives at a different phase on each pass of the full sweep over all 128 codes.

// File: rtl/ldo_ctl_pkg.sv
package ldo_ctl_pkg;

    localparam int ADDR_W   = 6;
    localparam int DATA_W   = 32;
    localparam int CODE_W   = 7;
    localparam int CODE_LSB = 8;
    localparam int RST_BIT  = 16;
    localparam int SYNC_N   = 2;

    localparam logic [ADDR_W-1:0] OFF_UPD  = ADDR_W'(6'h00);
    localparam logic [ADDR_W-1:0] OFF_REF  = ADDR_W'(6'h04);
    localparam logic [ADDR_W-1:0] OFF_CFG1 = ADDR_W'(6'h0C);
    localparam logic [ADDR_W-1:0] OFF_CFG2 = ADDR_W'(6'h10);

    localparam logic [DATA_W-1:0] REF_RESET = DATA_W'(1) << RST_BIT;

    typedef struct packed {
        logic              upd;
        logic              req_tgl;
        logic [CODE_W-1:0] snap;
        logic [DATA_W-1:0] refw;
        logic [DATA_W-1:0] cfg1;
        logic [DATA_W-1:0] cfg2;
    } bus_state_t;

    typedef struct packed {
        logic              seen;
        logic [CODE_W-1:0] active;
    } ref_state_t;

endpackage

// File: rtl/ldo_sync.sv
module ldo_sync #(
    parameter int W      = 1,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    localparam int CHAIN_W = W * STAGES;

    logic [CHAIN_W-1:0] chain_d, chain_q;

    always_comb begin
        chain_d = {chain_q[CHAIN_W-W-1:0], d};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= chain_d;
    end

    assign q = chain_q[CHAIN_W-1 -: W];
endmodule

// File: rtl/ldo_bus_regs.sv
module ldo_bus_regs
    import ldo_ctl_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              ack_sync,
    output logic [DATA_W-1:0] bus_rdata,
    output logic [DATA_W-1:0] cfg1,
    output logic [DATA_W-1:0] cfg2,
    output logic              ldo_rst,
    output logic              req_tgl,
    output logic [CODE_W-1:0] snap,
    output logic              upd,
    output logic              match
);
    bus_state_t st_d, st_q;
    logic [CODE_W-1:0] pending;

    always_comb begin
        st_d    = st_q;
        pending = st_q.refw[CODE_LSB +: CODE_W];
        match   = (ack_sync == st_q.req_tgl) && (st_q.snap == pending);

        if (bus_we) begin
            case (bus_addr)
                OFF_UPD: begin
                    st_d.upd = bus_wdata[0];
                    if (bus_wdata[0] && !st_q.upd) begin
                        st_d.req_tgl = ~st_q.req_tgl;
                        st_d.snap    = pending;
                    end
                end
                OFF_REF:  st_d.refw = bus_wdata;
                OFF_CFG1: st_d.cfg1 = bus_wdata;
                OFF_CFG2: st_d.cfg2 = bus_wdata;
                default:  ;
            endcase
        end

        bus_rdata = '0;
        case (bus_addr)
            OFF_UPD: begin
                bus_rdata[0] = st_q.upd;
                bus_rdata[1] = match;
            end
            OFF_REF:  bus_rdata = st_q.refw;
            OFF_CFG1: bus_rdata = st_q.cfg1;
            OFF_CFG2: bus_rdata = st_q.cfg2;
            default:  bus_rdata = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.refw <= REF_RESET;
        end else begin
            st_q <= st_d;
        end
    end

    assign cfg1    = st_q.cfg1;
    assign cfg2    = st_q.cfg2;
    assign ldo_rst = st_q.refw[RST_BIT];
    assign req_tgl = st_q.req_tgl;
    assign snap    = st_q.snap;
    assign upd     = st_q.upd;
endmodule

// File: rtl/ldo_ref_side.sv
module ldo_ref_side
    import ldo_ctl_pkg::*;
(
    input  logic              ref_clk,
    input  logic              rst_n,
    input  logic              req_tgl,
    input  logic [CODE_W-1:0] snap,
    output logic              ack_tgl,
    output logic [CODE_W-1:0] active
);
    ref_state_t st_d, st_q;
    logic       req_s;

    ldo_sync #(.W(1), .STAGES(SYNC_N)) u_req_sync (
        .clk   (ref_clk),
        .rst_n (rst_n),
        .d     (req_tgl),
        .q     (req_s)
    );

    always_comb begin
        st_d = st_q;
        if (req_s != st_q.seen) begin
            st_d.seen   = req_s;
            st_d.active = snap;
        end
    end

    always_ff @(posedge ref_clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ack_tgl = st_q.seen;
    assign active  = st_q.active;
endmodule

// File: rtl/ldo_ctl_regfile.sv
module ldo_ctl_regfile
    import ldo_ctl_pkg::*;
(
    input  logic              clk,
    input  logic              ref_clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic [DATA_W-1:0] ldo_cfg1_o,
    output logic [DATA_W-1:0] ldo_cfg2_o,
    output logic              ldo_rst_o,
    output logic [CODE_W-1:0] ret_code_o,
    output logic              code_match_o
);
    logic              req_tgl;
    logic              ack_tgl;
    logic              ack_sync;
    logic              upd;
    logic [CODE_W-1:0] snap;

    ldo_bus_regs u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_we    (bus_we),
        .bus_wdata (bus_wdata),
        .ack_sync  (ack_sync),
        .bus_rdata (bus_rdata),
        .cfg1      (ldo_cfg1_o),
        .cfg2      (ldo_cfg2_o),
        .ldo_rst   (ldo_rst_o),
        .req_tgl   (req_tgl),
        .snap      (snap),
        .upd       (upd),
        .match     (code_match_o)
    );

    ldo_ref_side u_ref (
        .ref_clk (ref_clk),
        .rst_n   (rst_n),
        .req_tgl (req_tgl),
        .snap    (snap),
        .ack_tgl (ack_tgl),
        .active  (ret_code_o)
    );

    ldo_sync #(.W(1), .STAGES(SYNC_N)) u_ack_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (ack_tgl),
        .q     (ack_sync)
    );
endmodule

// File: rtl/ldo_ctl_checker.sv
module ldo_ctl_checker
    import ldo_ctl_pkg::*;
(
    input logic              clk,
    input logic              ref_clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_we,
    input logic [DATA_W-1:0] bus_wdata,
    input logic [DATA_W-1:0] cfg1,
    input logic [DATA_W-1:0] cfg2,
    input logic              ldo_rst,
    input logic [CODE_W-1:0] ret_code,
    input logic              req_tgl,
    input logic [CODE_W-1:0] snap,
    input logic              upd
);
    logic mapped;
    assign mapped = (bus_addr == OFF_UPD) || (bus_addr == OFF_REF) ||
                    (bus_addr == OFF_CFG1) || (bus_addr == OFF_CFG2);

    AST_RST_BIT_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        bus_we && bus_addr == OFF_REF |=> ldo_rst == $past(bus_wdata[RST_BIT])); // R2

    AST_CFG1_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        bus_we && bus_addr == OFF_CFG1 |=> cfg1 == $past(bus_wdata)); // R3

    AST_CFG2_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        bus_we && bus_addr == OFF_CFG2 |=> cfg2 == $past(bus_wdata)); // R3

    AST_UNMAPPED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        bus_we && !mapped |=> $stable(cfg1) && $stable(cfg2) && $stable(ldo_rst) && $stable(req_tgl)); // R4

    AST_ACTIVE_FROM_SNAP: assert property (@(posedge ref_clk) disable iff (!rst_n)
        !$stable(ret_code) |-> ret_code == snap); // R5

    AST_UPD_STORE: assert property (@(posedge clk) disable iff (!rst_n)
        bus_we && bus_addr == OFF_UPD |=> upd == $past(bus_wdata[0])); // R6

    AST_NO_REARM: assert property (@(posedge clk) disable iff (!rst_n)
        bus_we && bus_addr == OFF_UPD && bus_wdata[0] && upd |=> $stable(req_tgl)); // R7
endmodule

bind ldo_ctl_regfile ldo_ctl_checker u_chk (
    .clk       (clk),
    .ref_clk   (ref_clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_we    (bus_we),
    .bus_wdata (bus_wdata),
    .cfg1      (ldo_cfg1_o),
    .cfg2      (ldo_cfg2_o),
    .ldo_rst   (ldo_rst_o),
    .ret_code  (ret_code_o),
    .req_tgl   (req_tgl),
    .snap      (snap),
    .upd       (upd)
);

// File: tb/sim_ldo_ctl_regfile.sv
module sim_ldo_ctl_regfile;
    localparam int CLK_PERIOD = 10;
    localparam int REF_PERIOD = 26;

    logic        clk = 1'b0;
    logic        ref_clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [5:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata, ldo_cfg1_o, ldo_cfg2_o;
    logic        ldo_rst_o, code_match_o;
    logic [6:0]  ret_code_o;

    int checks = 0;
    int fails  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;
    always #(REF_PERIOD/2) ref_clk = ~ref_clk;

    ldo_ctl_regfile u0 (
        .clk(clk), .ref_clk(ref_clk), .rst_n(rst_n),
        .bus_addr(bus_addr), .bus_we(bus_we), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .ldo_cfg1_o(ldo_cfg1_o), .ldo_cfg2_o(ldo_cfg2_o),
        .ldo_rst_o(ldo_rst_o), .ret_code_o(ret_code_o), .code_match_o(code_match_o)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_we = 1'b1; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [5:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic settle();
        repeat (6) @(posedge ref_clk);
        repeat (4) @(negedge clk);
    endtask

    task automatic arm();
        wr(6'h00, 32'h0);
        wr(6'h00, 32'h1);
        settle();
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        fails++;
        $display("FAIL watchdog actual=running expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        logic [31:0] v;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R1 reset state
        rd(6'h04, v); check("R1 ref word", v, 32'h0001_0000);
        check("R1 ldo_rst_o", {31'b0, ldo_rst_o}, 32'h1);
        rd(6'h0C, v); check("R1 cfg1", v, 32'h0);
        rd(6'h10, v); check("R1 cfg2", v, 32'h0);
        check("R1 ret_code_o", {25'b0, ret_code_o}, 32'h0);
        rd(6'h00, v); check("R1 update word", v, 32'h2);

        // R3 configuration words
        wr(6'h0C, 32'hA5C3_98C2);
        rd(6'h0C, v); check("R3 cfg1 readback", v, 32'hA5C3_98C2);
        check("R3 cfg1 port", ldo_cfg1_o, 32'hA5C3_98C2);
        wr(6'h10, 32'h004A_0060);
        rd(6'h10, v); check("R3 cfg2 readback", v, 32'h004A_0060);
        check("R3 cfg2 port", ldo_cfg2_o, 32'h004A_0060);

        // R2 reference word, reset released, pending 0x2A
        wr(6'h04, 32'hDEAC_2A00);
        rd(6'h04, v); check("R2 ref readback", v, 32'hDEAC_2A00);
        check("R2 ldo_rst_o released", {31'b0, ldo_rst_o}, 32'h0);
        // R8 status drops on new pending value
        rd(6'h00, v); check("R8 status after pending write", v, 32'h0);
        // R5 pending alone does not move active code
        settle();
        check("R5 active unchanged", {25'b0, ret_code_o}, 32'h0);

        // R6 arm transfers the code
        arm();
        check("R6 active loaded", {25'b0, ret_code_o}, 32'h2A);
        rd(6'h00, v); check("R6 R8 update word after transfer", v, 32'h3);

        // R7 re-write of 1 and write of 0 do nothing
        wr(6'h04, 32'h0000_2000);
        check("R2 ldo_rst_o cleared word", {31'b0, ldo_rst_o}, 32'h0);
        wr(6'h00, 32'h1);
        settle();
        check("R7 rewrite 1 no transfer", {25'b0, ret_code_o}, 32'h2A);
        wr(6'h00, 32'h0);
        settle();
        check("R7 write 0 keeps active", {25'b0, ret_code_o}, 32'h2A);
        rd(6'h00, v); check("R7 R8 update word", v, 32'h0);
        wr(6'h04, 32'h0001_2000);
        check("R2 ldo_rst_o set", {31'b0, ldo_rst_o}, 32'h1);

        // R4 unmapped offsets
        for (int a = 0; a < 64; a++) begin
            if (a != 0 && a != 4 && a != 12 && a != 16) begin
                wr(6'(a), 32'hFFFF_FFFF);
                rd(6'(a), v); check("R4 unmapped read", v, 32'h0);
            end
        end
        rd(6'h04, v); check("R4 ref untouched", v, 32'h0001_2000);
        rd(6'h0C, v); check("R4 cfg1 untouched", v, 32'hA5C3_98C2);
        rd(6'h10, v); check("R4 cfg2 untouched", v, 32'h004A_0060);
        rd(6'h00, v); check("R4 update untouched", v, 32'h0);
        check("R4 active untouched", {25'b0, ret_code_o}, 32'h2A);

        // R9 sweep of every code
        for (int c = 0; c < 128; c++) begin
            wr(6'h04, 32'(c) << 8);
            arm();
            check("R9 code transfer", {25'b0, ret_code_o}, 32'(c));
            check("R8 match after sweep step", {31'b0, code_match_o}, 32'h1);
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule